// File: doc/BRIEF.md
# Age-Ordered Collapsing Issue Queue

This block is the scheduling window of an out-of-order integer pipeline. It holds 20 renamed operations, each carrying two source physical-register tags with a ready bit per source and an opaque payload. Every cycle it listens to a bus of wakeup tags produced by completing operations. When a tag matches, it marks that source ready. It then hands up to four fully ready operations to the execution ports.

The queue keeps physical position equal to age: slot 0 always holds the oldest operation. The surviving entries slide down every cycle to close the holes that issued operations leave behind. Up to four new operations per cycle join directly above the survivors. Because the order is physical, a simple positional priority encoder selects the oldest ready work. A space signal tells the renamer whether a full group of four may be written, and a flush empties the window in one cycle.

Top module: `iq_core`

## Requirements
- R1: After reset the queue is empty: no issue port is valid and `space_ok` is 1.
- R2: An entry is eligible for issue only when it is valid and both of its source-ready bits are set. An entry with an unready source is never issued.
- R3: At most four operations issue per cycle. Valid issue ports are contiguous from port 0, and lower ports carry older operations.
- R4: The operations issued are the oldest eligible ones. Port k carries the (k+1)-th oldest eligible entry.
- R5: A wakeup tag that matches a stored source in cycle t sets that source ready from cycle t+1. The entry cannot issue in cycle t because of that wakeup.
- R6: Issued entries leave the queue at the clock edge. Remaining entries keep their relative age order and occupy the lowest slots with no gaps.
- R7: Insert slots are taken in ascending slot order, and slots whose valid bit is 0 are skipped. Accepted operations are placed directly above the survivors, younger than all of them, and may issue from the next cycle at the earliest.
- R8: The sources of an operation being inserted are compared against the wakeup bus in the insert cycle. A match makes that source ready when the entry lands.
- R9: `space_ok` is 1 exactly when at least four slots are free once this cycle's selected operations are removed. The flush input does not affect this. When `space_ok` is 0, the inserts of that cycle are dropped.
- R10: While `flush` is 1, no issue port is valid and that cycle's inserts are dropped. From the next cycle the queue is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| flush | input | 1 | Empty the queue at the next edge; squashes this cycle's issue and inserts |
| ins_vld | input | INS_W | Valid bit per insert slot |
| ins_src0 | input | INS_W*7 | First source tag per insert slot |
| ins_rdy0 | input | INS_W | First source already ready |
| ins_src1 | input | INS_W*7 | Second source tag per insert slot |
| ins_rdy1 | input | INS_W | Second source already ready |
| ins_pay | input | INS_W*16 | Payload per insert slot |
| wk_vld | input | WAKE_N | Valid bit per wakeup lane |
| wk_tag | input | WAKE_N*7 | Tag per wakeup lane |
| iss_vld | output | ISS_W | Valid bit per issue port |
| iss_pay | output | ISS_W*16 | Payload per issue port, zero when that port is idle |
| space_ok | output | 1 | At least four slots free after this cycle's issue |

## Verification
The properties assume that `flush` and all insert and wakeup inputs are stable around the clock edge. They also assume that the insert and wakeup buses carry known values whenever reset is released. The occupancy properties assume that the only ways to add entries are the insert slots. The bench drives every input at the falling edge, so values stay steady through the sampling point and the next rising edge. It keeps tags within a small range so that wakeups hit stored sources often. It holds inserts off for the cycles of the reset synchronizer.

// File: rtl/iq_pkg.sv
package iq_pkg;
  localparam int TAG_W = 7;
  localparam int PAY_W = 16;

  typedef struct packed {
    logic             vld;
    logic [TAG_W-1:0] src0;
    logic             rdy0;
    logic [TAG_W-1:0] src1;
    logic             rdy1;
    logic [PAY_W-1:0] pay;
  } iq_ent_t;
endpackage

// File: rtl/iq_wake.sv
module iq_wake
  import iq_pkg::*;
#(
  parameter int WAKE_N = 4
) (
  input  iq_ent_t                   ent_i,
  input  logic [WAKE_N-1:0]         wk_vld,
  input  logic [WAKE_N*TAG_W-1:0]   wk_tag,
  output iq_ent_t                   ent_o
);
  always_comb begin
    ent_o = ent_i;
    for (int w = 0; w < WAKE_N; w++) begin
      if (wk_vld[w]) begin
        if (wk_tag[w*TAG_W +: TAG_W] == ent_i.src0) ent_o.rdy0 = 1'b1;
        if (wk_tag[w*TAG_W +: TAG_W] == ent_i.src1) ent_o.rdy1 = 1'b1;
      end
    end
  end
endmodule

// File: rtl/iq_select.sv
module iq_select #(
  parameter  int DEPTH = 20,
  parameter  int ISS_W = 4,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int SEL_W = $clog2(ISS_W + 1)
) (
  input  logic [DEPTH-1:0]            req,
  output logic [DEPTH-1:0]            gnt,
  output logic [ISS_W-1:0]            pvld,
  output logic [ISS_W-1:0][IDX_W-1:0] idx
);
  logic [SEL_W-1:0] taken;

  // Positional priority: slot 0 is the oldest, so a low-to-high scan is age order.
  always_comb begin
    taken = '0;
    gnt   = '0;
    pvld  = '0;
    idx   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (req[i] && (taken < SEL_W'(ISS_W))) begin
        gnt[i]      = 1'b1;
        pvld[taken] = 1'b1;
        idx[taken]  = IDX_W'(i);
        taken       = taken + 1'b1;
      end
    end
  end
endmodule

// File: rtl/iq_compact.sv
module iq_compact
  import iq_pkg::*;
#(
  parameter  int DEPTH = 20,
  parameter  int INS_W = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  iq_ent_t          cur [DEPTH],
  input  logic [DEPTH-1:0] gnt,
  input  iq_ent_t          ins [INS_W],
  input  logic             ins_en,
  output iq_ent_t          nxt [DEPTH],
  output logic             space_ok
);
  logic [CNT_W-1:0] pos;

  always_comb begin
    pos = '0;
    for (int k = 0; k < DEPTH; k++) nxt[k] = '0;
    // Survivors slide down in order; pos ends as the survivor count.
    for (int i = 0; i < DEPTH; i++) begin
      if (cur[i].vld && !gnt[i]) begin
        nxt[pos] = cur[i];
        pos      = pos + 1'b1;
      end
    end
    space_ok = (pos <= CNT_W'(DEPTH - INS_W));
    // New operations stack above the survivors, slot order, gaps skipped.
    if (ins_en && space_ok) begin
      for (int j = 0; j < INS_W; j++) begin
        if (ins[j].vld && (pos < CNT_W'(DEPTH))) begin
          nxt[pos] = ins[j];
          pos      = pos + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/iq_core.sv
module iq_core
  import iq_pkg::*;
#(
  parameter int DEPTH  = 20,
  parameter int INS_W  = 4,
  parameter int ISS_W  = 4,
  parameter int WAKE_N = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic [INS_W-1:0]         ins_vld,
  input  logic [INS_W*TAG_W-1:0]   ins_src0,
  input  logic [INS_W-1:0]         ins_rdy0,
  input  logic [INS_W*TAG_W-1:0]   ins_src1,
  input  logic [INS_W-1:0]         ins_rdy1,
  input  logic [INS_W*PAY_W-1:0]   ins_pay,
  input  logic [WAKE_N-1:0]        wk_vld,
  input  logic [WAKE_N*TAG_W-1:0]  wk_tag,
  output logic [ISS_W-1:0]         iss_vld,
  output logic [ISS_W*PAY_W-1:0]   iss_pay,
  output logic                     space_ok
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [1:0]              rsync_q;
  logic                    rst_q_n;
  iq_ent_t                 ent_q   [DEPTH];
  iq_ent_t                 ent_w   [DEPTH];
  iq_ent_t                 ent_c   [DEPTH];
  iq_ent_t                 ent_d   [DEPTH];
  iq_ent_t                 ins_raw [INS_W];
  iq_ent_t                 ins_w   [INS_W];
  logic [DEPTH-1:0]        occ;
  logic [DEPTH-1:0]        req;
  logic [DEPTH-1:0]        gnt;
  logic [ISS_W-1:0]        pvld;
  logic [ISS_W-1:0][IDX_W-1:0] idx;
  logic                    upd_en;

  // Reset asserts at once, releases after two clean edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_q_n = rsync_q[1];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    assign occ[i] = ent_q[i].vld;
    assign req[i] = ent_q[i].vld & ent_q[i].rdy0 & ent_q[i].rdy1;
    iq_wake #(.WAKE_N(WAKE_N)) u_wk (
      .ent_i(ent_q[i]), .wk_vld(wk_vld), .wk_tag(wk_tag), .ent_o(ent_w[i]));
  end

  for (genvar j = 0; j < INS_W; j++) begin : g_ins
    always_comb begin
      ins_raw[j].vld  = ins_vld[j];
      ins_raw[j].src0 = ins_src0[j*TAG_W +: TAG_W];
      ins_raw[j].rdy0 = ins_rdy0[j];
      ins_raw[j].src1 = ins_src1[j*TAG_W +: TAG_W];
      ins_raw[j].rdy1 = ins_rdy1[j];
      ins_raw[j].pay  = ins_pay[j*PAY_W +: PAY_W];
    end
    iq_wake #(.WAKE_N(WAKE_N)) u_wk (
      .ent_i(ins_raw[j]), .wk_vld(wk_vld), .wk_tag(wk_tag), .ent_o(ins_w[j]));
  end

  iq_select #(.DEPTH(DEPTH), .ISS_W(ISS_W)) u_sel (
    .req(req), .gnt(gnt), .pvld(pvld), .idx(idx));

  iq_compact #(.DEPTH(DEPTH), .INS_W(INS_W)) u_cmp (
    .cur(ent_w), .gnt(gnt), .ins(ins_w), .ins_en(~flush),
    .nxt(ent_c), .space_ok(space_ok));

  assign iss_vld = pvld & {ISS_W{~flush}};

  for (genvar k = 0; k < ISS_W; k++) begin : g_iss
    assign iss_pay[k*PAY_W +: PAY_W] = iss_vld[k] ? ent_q[idx[k]].pay : '0;
  end

  // Next-state selection and clock enable.
  always_comb begin
    for (int i = 0; i < DEPTH; i++) ent_d[i] = flush ? '0 : ent_c[i];
    upd_en = flush | (|occ) | (|ins_vld);
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
    end else if (upd_en) begin
      ent_q <= ent_d;
    end
  end
endmodule

// File: rtl/iq_core_chk.sv
module iq_core_chk #(
  parameter int DEPTH = 20,
  parameter int INS_W = 4,
  parameter int ISS_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic [INS_W-1:0] ins_vld,
  input logic [ISS_W-1:0] iss_vld,
  input logic             space_ok,
  input logic [DEPTH-1:0] occ
);
  AST_ISS_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
    ((iss_vld & (iss_vld + 1'b1)) == '0)); // R3

  AST_ISS_FROM_OCC: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(iss_vld) <= $countones(occ))); // R2

  AST_OCC_DENSE: assert property (@(posedge clk) disable iff (!rst_n)
    ((occ & (occ + 1'b1)) == '0)); // R6

  AST_DRAIN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && ins_vld == '0) |=>
      ($countones(occ) == $past($countones(occ)) - $past($countones(iss_vld)))); // R6

  AST_NO_ROOM_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && !space_ok) |=>
      ($countones(occ) == $past($countones(occ)) - $past($countones(iss_vld)))); // R9

  AST_FLUSH_SQUASH: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (iss_vld == '0)); // R10

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (occ == '0) && space_ok); // R10
endmodule

bind iq_core iq_core_chk #(.DEPTH(DEPTH), .INS_W(INS_W), .ISS_W(ISS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .ins_vld(ins_vld),
  .iss_vld(iss_vld), .space_ok(space_ok), .occ(occ));

// File: tb/sim_iq_core.sv
`timescale 1ns/1ps
module sim_iq_core;
  localparam int D  = 20;
  localparam int NI = 4;
  localparam int NS = 4;
  localparam int NW = 4;
  localparam int TW = 7;
  localparam int PW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic [NI-1:0]    ins_vld = '0;
  logic [NI*TW-1:0] ins_src0 = '0, ins_src1 = '0;
  logic [NI-1:0]    ins_rdy0 = '0, ins_rdy1 = '0;
  logic [NI*PW-1:0] ins_pay = '0;
  logic [NW-1:0]    wk_vld = '0;
  logic [NW*TW-1:0] wk_tag = '0;
  logic [NS-1:0]    iss_vld;
  logic [NS*PW-1:0] iss_pay;
  logic             space_ok;

  int nchk = 0, nfail = 0;
  int m_cnt = 0;
  logic [TW-1:0] m_s0 [D], m_s1 [D];
  bit            m_r0 [D], m_r1 [D];
  logic [PW-1:0] m_pay [D];
  int seq = 1;

  always #5 clk = ~clk;

  iq_core u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .ins_vld(ins_vld),
    .ins_src0(ins_src0), .ins_rdy0(ins_rdy0), .ins_src1(ins_src1), .ins_rdy1(ins_rdy1),
    .ins_pay(ins_pay), .wk_vld(wk_vld), .wk_tag(wk_tag),
    .iss_vld(iss_vld), .iss_pay(iss_pay), .space_ok(space_ok));

  function automatic bit woke(logic [TW-1:0] t);
    for (int w = 0; w < NW; w++)
      if (wk_vld[w] && wk_tag[w*TW +: TW] == t) return 1'b1;
    return 1'b0;
  endfunction

  task automatic report();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  task automatic clr_in();
    ins_vld = '0; ins_rdy0 = '0; ins_rdy1 = '0; wk_vld = '0; flush = 1'b0;
  endtask

  task automatic put(int s, int t0, bit r0, int t1, bit r1);
    ins_vld[s] = 1'b1;
    ins_src0[s*TW +: TW] = TW'(t0); ins_rdy0[s] = r0;
    ins_src1[s*TW +: TW] = TW'(t1); ins_rdy1[s] = r1;
    ins_pay[s*PW +: PW]  = PW'(seq);
    seq++;
  endtask

  task automatic wake(int l, int t);
    wk_vld[l] = 1'b1; wk_tag[l*TW +: TW] = TW'(t);
  endtask

  // Called just after a falling edge with inputs set; checks, then crosses one rising edge.
  task automatic step(string rq);
    logic [NS-1:0]    e_vld;
    logic [NS*PW-1:0] e_pay;
    bit               sel [D];
    int               nis, nc;
    bit               e_sp;
    logic [TW-1:0]    n_s0 [D], n_s1 [D];
    bit               n_r0 [D], n_r1 [D];
    logic [PW-1:0]    n_pay [D];
    #2;
    e_vld = '0; e_pay = '0; nis = 0;
    for (int i = 0; i < D; i++) begin
      sel[i] = 1'b0;
      if (i < m_cnt && m_r0[i] && m_r1[i] && nis < NS) begin
        sel[i] = 1'b1;
        if (!flush) begin e_vld[nis] = 1'b1; e_pay[nis*PW +: PW] = m_pay[i]; end
        nis++;
      end
    end
    e_sp = (D - (m_cnt - nis)) >= NI;
    nchk++;
    if (iss_vld !== e_vld || iss_pay !== e_pay) begin
      nfail++;
      $display("FAIL %s issue vld=%b pay=%h expected vld=%b pay=%h", rq, iss_vld, iss_pay, e_vld, e_pay);
    end
    nchk++;
    if (space_ok !== e_sp) begin
      nfail++;
      $display("FAIL %s space_ok=%b expected %b", rq, space_ok, e_sp);
    end
    nc = 0;
    for (int i = 0; i < m_cnt; i++) begin
      if (!sel[i]) begin
        n_s0[nc] = m_s0[i]; n_s1[nc] = m_s1[i]; n_pay[nc] = m_pay[i];
        n_r0[nc] = m_r0[i] | woke(m_s0[i]); n_r1[nc] = m_r1[i] | woke(m_s1[i]);
        nc++;
      end
    end
    if (e_sp) begin
      for (int j = 0; j < NI; j++) begin
        if (ins_vld[j]) begin
          n_s0[nc] = ins_src0[j*TW +: TW]; n_s1[nc] = ins_src1[j*TW +: TW];
          n_pay[nc] = ins_pay[j*PW +: PW];
          n_r0[nc] = ins_rdy0[j] | woke(n_s0[nc]);
          n_r1[nc] = ins_rdy1[j] | woke(n_s1[nc]);
          nc++;
        end
      end
    end
    if (flush) nc = 0;
    @(posedge clk);
    m_cnt = nc;
    for (int i = 0; i < nc; i++) begin
      m_s0[i] = n_s0[i]; m_s1[i] = n_s1[i]; m_r0[i] = n_r0[i]; m_r1[i] = n_r1[i]; m_pay[i] = n_pay[i];
    end
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    @(negedge clk);
    step("R1");
    step("R1");
    rst_n = 1'b1;
    step("R1"); step("R1"); step("R1");

    // R7 / R3: four ready ops, then all four issue in slot order
    clr_in(); for (int s = 0; s < NI; s++) put(s, 1, 1, 2, 1);
    step("R7");
    clr_in(); step("R3");
    step("R1");

    // R2 / R5: one op waits on tag 10; wakeup does not let it issue the same cycle
    clr_in(); put(0, 10, 0, 11, 1); put(1, 12, 1, 13, 1);
    step("R7");
    clr_in(); wake(2, 10);
    step("R5");
    clr_in(); step("R5");
    step("R2");

    // R7: gapped insert slots
    clr_in(); put(1, 3, 1, 4, 1); put(3, 5, 1, 6, 1);
    step("R7");
    clr_in(); step("R7");

    // R8: wakeup hits an op during its insert cycle
    clr_in(); put(0, 20, 0, 21, 0); wake(0, 20); wake(3, 21);
    step("R8");
    clr_in(); step("R8");

    // R9: fill with blocked ops until inserts are refused
    for (int c = 0; c < 7; c++) begin
      clr_in(); for (int s = 0; s < NI; s++) put(s, 50, 0, 51, 1);
      step("R9");
    end
    // R4 / R6: release them; oldest four go first, the rest slide down
    clr_in(); wake(1, 50);
    step("R9");
    for (int c = 0; c < 6; c++) begin clr_in(); step(c == 0 ? "R4" : "R6"); end

    // R10: flush drops queue contents and same-cycle inserts
    clr_in(); for (int s = 0; s < 3; s++) put(s, 60, 0, 61, 1);
    step("R10");
    clr_in(); flush = 1'b1; put(0, 1, 1, 2, 1); put(1, 60, 0, 61, 1);
    step("R10");
    clr_in(); wake(0, 60);
    step("R10");
    clr_in(); step("R10");

    // R4 / R6 / R9: random traffic against the model
    for (int c = 0; c < 5000; c++) begin
      clr_in();
      for (int s = 0; s < NI; s++)
        if ($urandom_range(0, 1) == 1)
          put(s, $urandom_range(0, 15), $urandom_range(0, 2) != 0,
                 $urandom_range(0, 15), $urandom_range(0, 2) != 0);
      for (int l = 0; l < NW; l++)
        if ($urandom_range(0, 1) == 1) wake(l, $urandom_range(0, 15));
      flush = ($urandom_range(0, 99) == 0);
      step("R4");
    end
    report();
  end
endmodule